// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Emulator

This block stands in for a small serial EEPROM of 64 words of 16 bits. Software never sees a real serial pin. It writes a control register whose bits act as chip-select, serial clock and data-in, and it reads the data-out bit back from the same register. The block detects edges by comparing each control write with the previous one. It collects a nine-bit command: a three-bit opcode followed by a six-bit word address. When the opcode is a read, it shifts the addressed word out MSB first. Each falling clock edge moves to the next bit, and the stream runs on into the following words.

A second register offers a shortcut. Software writes a word address together with a start bit, then reads the register back. The read returns the stored word and a done flag at once. The storage array has its own load port, so the contents can be placed in it before software uses either access path.

Top module: `eeprom_bitbang_emu`

## Requirements
- R1: After reset the control register (byte offset 0x0) reads 0x0000_0188 and the word-read register (byte offset 0x4) reads 0.
- R2: The control register stores only bit 0 (clock), bit 1 (select), bit 2 (data-in), bits 5:4 (write-enable field) and bit 6 (request). Reads return those stored bits, data-out in bit 3, and zero in all other bits except 8:7.
- R3: A control write with select (bit 1) low changes nothing but the stored bits. A read in progress keeps presenting the same data-out bit, whatever the clock does.
- R4: A write that raises select clears the command shift register, the command bit count, the output bit index and the active-read flag, so data-out reads 1.
- R5: Each rising clock edge with select high shifts data-in into the command. On the ninth bit, the first three bits shifted in are compared with the read opcode 3'b110; a match starts a read of the word given by the last six bits.
- R6: After a read starts, the first falling clock edge presents bit 15 of the addressed word. Each further falling edge presents the next lower bit. After bit 0 the stream continues with bit 15 of the next word, and word 63 is followed by word 0.
- R7: While no read is active, data-out (bit 3) reads 1.
- R8: Every control read returns bit 8 (present) and bit 7 (granted) set.
- R9: A read of the word-read register, when the last value written there has the start bit (bit 0) set and an address (bits 15:8) of 63 or less, returns the addressed word in bits 31:16 and the done bit (bit 4) set. Bits 15:8 and the other low bits are kept as written, and the start bit reads 0.
- R10: Under the same conditions, but with an address of 64 to 255, the read returns the written value with the start bit cleared and the done bit set. No word data is added.
- R11: When the last value written to the word-read register has the start bit clear, reads return that value unchanged.
- R12: A control write with select high whose clock bit equals the stored clock bit shifts nothing and moves no bit index, whatever data-in is.
- R13: A single write that raises select and the clock together first clears the state, then shifts its data-in bit as the first command bit.
- R14: Words placed through the load port are the ones both read paths return from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset (0x0 control, 0x4 word read) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| ld_en | input | 1 | Storage load strobe |
| ld_addr | input | 6 | Storage load word address |
| ld_data | input | 16 | Storage load word |

## Verification
Two functions can land in one control write: clearing the state on a select rising edge, and processing a clock edge. The bench provokes this with one write that takes select and the clock from low to high together, with data-in at 1. That bit must count as the first opcode bit. The bench then sends eight more bits, and the read must return the addressed word, so a design that drops or double-counts the bit delivers the wrong data. Two cases with select already high isolate the halves: a write with an unchanged clock must not shift, which would trigger the command decode early, and a select rise without a clock change must only clear the state.

// File: rtl/mwe_pkg.sv
// Package: shared bit positions and types for the serial EEPROM emulator.
// Assumes a 32-bit register bus and 16-bit storage words.
package mwe_pkg;
    // control register bit positions
    localparam int CTL_SK   = 0;
    localparam int CTL_CS   = 1;
    localparam int CTL_DI   = 2;
    localparam int CTL_DO   = 3;
    localparam int CTL_GNT  = 7;
    localparam int CTL_PRES = 8;

    // word-read register fields
    localparam int WRD_START    = 0;
    localparam int WRD_DONE     = 4;
    localparam int WRD_ADDR_LSB = 8;
    localparam int WRD_ADDR_W   = 8;
    localparam int WRD_DATA_LSB = 16;

    localparam logic [2:0] OP_READ = 3'b110;

    // control bits that survive a write
    typedef struct packed {
        logic       req;
        logic [1:0] fwe;
        logic       di;
        logic       cs;
        logic       sk;
    } ctl_keep_t;

    // pick the retained bits out of a control write
    function automatic ctl_keep_t keep_of(input logic [31:0] w);
        ctl_keep_t k;
        k.req = w[6];
        k.fwe = w[5:4];
        k.di  = w[CTL_DI];
        k.cs  = w[CTL_CS];
        k.sk  = w[CTL_SK];
        return k;
    endfunction
endpackage

// File: rtl/mwe_store.sv
// Module: word storage with one load port and two combinational read ports.
// Assumes contents are loaded before use; the array has no reset.
module mwe_store #(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [AW-1:0]     rd_a_addr,
    output logic [WORD_W-1:0] rd_a_data,
    input  logic [AW-1:0]     rd_b_addr,
    output logic [WORD_W-1:0] rd_b_data
);
    logic [WORD_W-1:0] mem_q [WORDS];

    // load one word per cycle
    always_ff @(posedge clk) begin
        if (ld_en) mem_q[ld_addr] <= ld_data;
    end

    // read ports
    assign rd_a_data = mem_q[rd_a_addr];
    assign rd_b_data = mem_q[rd_b_addr];
endmodule

// File: rtl/mwe_serial.sv
// Module: bit-banged serial engine. Finds clock and select edges by comparing
// each control write with the stored copy, collects the command, and runs a
// bit index over the storage for reads. Assumes one control write per cycle.
module mwe_serial
    import mwe_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    localparam int AW    = $clog2(WORDS),
    localparam int BW    = $clog2(WORD_W),
    localparam int IW    = AW + BW,
    localparam int CMD_BITS = AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  ctl_keep_t         ctl_new,
    input  logic [WORD_W-1:0] word_data,
    output logic [AW-1:0]     word_sel,
    output ctl_keep_t         ctl_keep,
    output logic              data_out
);
    localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(CMD_BITS);

    ctl_keep_t             keep_q;
    logic [CMD_BITS-1:0]   shift_q, shift_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [IW-1:0]         idx_q, idx_d;
    logic                  reading_q, reading_d;
    logic [BW-1:0]         bit_pos;

    // next-state of the serial protocol for one control write
    always_comb begin
        shift_d   = shift_q;
        cnt_d     = cnt_q;
        idx_d     = idx_q;
        reading_d = reading_q;
        if (ctl_wr && ctl_new.cs) begin
            if (!keep_q.cs) begin
                shift_d   = '0;
                cnt_d     = '0;
                idx_d     = '0;
                reading_d = 1'b0;
            end
            if (ctl_new.sk != keep_q.sk) begin
                if (!ctl_new.sk) begin
                    idx_d = idx_d + 1'b1;
                end else begin
                    shift_d = {shift_d[CMD_BITS-2:0], ctl_new.di};
                    if (cnt_d != '1) cnt_d = cnt_d + 1'b1;
                    if (cnt_d == CNT_FIRE && !reading_d) begin
                        idx_d     = {shift_d[AW-1:0], {BW{1'b0}}} - 1'b1;
                        reading_d = (shift_d[CMD_BITS-1 -: 3] == OP_READ);
                    end
                end
            end
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q    <= '0;
            shift_q   <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            reading_q <= 1'b0;
        end else begin
            if (ctl_wr) keep_q <= ctl_new;
            shift_q   <= shift_d;
            cnt_q     <= cnt_d;
            idx_q     <= idx_d;
            reading_q <= reading_d;
        end
    end

    // data-out selection: MSB of each word first
    assign word_sel = idx_q[IW-1:BW];
    assign bit_pos  = ~idx_q[BW-1:0];
    assign data_out = reading_q ? word_data[bit_pos] : 1'b1;
    assign ctl_keep = keep_q;

    AST_CS_LOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_new.cs) |=> ($stable(cnt_q) && $stable(idx_q) && $stable(reading_q) && $stable(shift_q))); // R3
    AST_CS_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_new.cs && !keep_q.cs && (ctl_new.sk == keep_q.sk)) |=> (cnt_q == '0 && idx_q == '0 && !reading_q)); // R4
    AST_FALL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_new.cs && keep_q.cs && keep_q.sk && !ctl_new.sk) |=> (idx_q == IW'($past(idx_q) + 1'b1))); // R6
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_new.cs && keep_q.cs && (ctl_new.sk == keep_q.sk)) |=> ($stable(cnt_q) && $stable(idx_q) && $stable(reading_q))); // R12
endmodule

// File: rtl/mwe_word_reg.sv
// Module: parallel word-read register. Holds the last written value and
// forms the read value from it and the addressed storage word.
// Assumes WORD_W is at most 16 so the word fits in bits 31:16.
module mwe_word_reg
    import mwe_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic [WORD_W-1:0] word_data,
    output logic [AW-1:0]     word_sel,
    output logic [31:0]       rd_value
);
    localparam logic [WRD_ADDR_W-1:0] LAST_IDX = WRD_ADDR_W'(WORDS - 1);

    logic [31:0] wreg_q;
    logic [31:0] base;
    logic        in_range;

    // hold the last written value
    always_ff @(posedge clk) begin
        if (!rst_n)  wreg_q <= '0;
        else if (wr) wreg_q <= wdata;
    end

    // read value: raw when idle, done plus word when started
    always_comb begin
        base     = wreg_q;
        base[WRD_START] = 1'b0;
        in_range = wreg_q[WRD_ADDR_LSB +: WRD_ADDR_W] <= LAST_IDX;
        if (!wreg_q[WRD_START]) begin
            rd_value = wreg_q;
        end else begin
            rd_value = base;
            rd_value[WRD_DONE] = 1'b1;
            if (in_range)
                rd_value = rd_value | ({{(32-WORD_W){1'b0}}, word_data} << WRD_DATA_LSB);
        end
    end

    assign word_sel = wreg_q[WRD_ADDR_LSB +: AW];
endmodule

// File: rtl/eeprom_bitbang_emu.sv
// Module: top of the serial EEPROM emulator. Decodes the register bus,
// registers read data one cycle after the strobe, and ties the serial
// engine and word-read register to the shared storage.
// Assumes reads and writes have no side effect beyond the named registers.
module eeprom_bitbang_emu
    import mwe_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 4,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data
);
    localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] WRD_OFF = ADDR_W'(4);

    logic              ctl_hit, wrd_hit;
    ctl_keep_t         keep;
    logic              data_out;
    logic [AW-1:0]     ser_sel, wrd_sel;
    logic [WORD_W-1:0] ser_word, wrd_word;
    logic [31:0]       wrd_value, ctl_value, rd_mux;

    assign ctl_hit = (bus_addr == CTL_OFF);
    assign wrd_hit = (bus_addr == WRD_OFF);

    mwe_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_a_addr(ser_sel), .rd_a_data(ser_word),
        .rd_b_addr(wrd_sel), .rd_b_data(wrd_word)
    );

    mwe_serial #(.WORDS(WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .ctl_wr(bus_wr && ctl_hit),
        .ctl_new(keep_of(bus_wdata)), .word_data(ser_word),
        .word_sel(ser_sel), .ctl_keep(keep), .data_out(data_out)
    );

    mwe_word_reg #(.WORDS(WORDS), .WORD_W(WORD_W)) u_word (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr && wrd_hit), .wdata(bus_wdata),
        .word_data(wrd_word), .word_sel(wrd_sel), .rd_value(wrd_value)
    );

    // control read value: retained bits, data-out, present and granted
    assign ctl_value = {23'b0, 1'b1, 1'b1, keep.req, keep.fwe, data_out,
                        keep.di, keep.cs, keep.sk};

    // read multiplexer
    always_comb begin
        if (ctl_hit)      rd_mux = ctl_value;
        else if (wrd_hit) rd_mux = wrd_value;
        else              rd_mux = '0;
    end

    // registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    AST_CTL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ctl_hit) |=> (bus_rvalid && bus_rdata[CTL_PRES] && bus_rdata[CTL_GNT])); // R8
endmodule

// File: tb/eeprom_bitbang_emu_tb.sv
module eeprom_bitbang_emu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t       sb_q[$];
    item_t       cur;
    logic [15:0] img [64];
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    eeprom_bitbang_emu u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    function automatic logic [15:0] pattern(input int i);
        return 16'(i * 16'h1F3 + 16'h5A5A);
    endfunction

    function automatic logic [31:0] ctl_exp(input logic sk, cs, di, dout);
        return 32'h180 | {28'b0, dout, di, cs, sk};
    endfunction

    // driver tasks: called at a falling edge, return at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ctl(input logic sk, cs, di);
        wr(4'h0, {29'b0, di, cs, sk});
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic load(input int a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = 6'(a); ld_data = d; img[a] = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // shift a nine-bit command with select already high, from bit 8
    task automatic send_cmd(input logic [2:0] op, input logic [5:0] a, input int first);
        logic [8:0] c;
        c = {op, a};
        for (int i = first; i >= 0; i--) begin
            ctl(1'b0, 1'b1, c[i]);
            ctl(1'b1, 1'b1, c[i]);
        end
    endtask

    // step n falling edges from the current stream position and check data-out
    task automatic read_bits(input int w, input int b, input int n, input string tag);
        int ww, bb;
        ww = w; bb = b;
        for (int k = 0; k < n; k++) begin
            ctl(1'b0, 1'b1, 1'b0);
            expect_rd(4'h0, ctl_exp(1'b0, 1'b1, 1'b0, img[ww][bb]), tag);
            ctl(1'b1, 1'b1, 1'b0);
            if (bb == 0) begin bb = 15; ww = (ww + 1) % 64; end
            else bb--;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data %h expected none", bus_rdata);
            end else begin
                cur = sb_q.pop_front();
                checks++;
                if (bus_rdata !== cur.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", cur.tag, bus_rdata, cur.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        expect_rd(4'h0, 32'h0000_0188, "R1");
        expect_rd(4'h4, 32'h0000_0000, "R1");
        // R14: preload the whole array
        for (int i = 0; i < 64; i++) load(i, pattern(i));

        // R2: only retained bits stored, select low
        wr(4'h0, 32'hFFFF_FFFD);
        expect_rd(4'h0, 32'h0000_01FD, "R2");

        // R5 R6: read word 5, continue into word 6
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        send_cmd(3'b110, 6'd5, 8);
        read_bits(5, 15, 18, "R6");

        // R6: wrap from word 63 to word 0
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        send_cmd(3'b110, 6'd63, 8);
        read_bits(63, 15, 17, "R6");

        // R5 R7: non-read opcode leaves data-out at 1
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        send_cmd(3'b101, 6'd7, 8);
        ctl(1'b0, 1'b1, 1'b0);
        expect_rd(4'h0, ctl_exp(1'b0, 1'b1, 1'b0, 1'b1), "R7");
        ctl(1'b1, 1'b1, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        expect_rd(4'h0, ctl_exp(1'b0, 1'b1, 1'b0, 1'b1), "R5");

        // R3: select low freezes the stream position
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        send_cmd(3'b110, 6'd9, 8);
        read_bits(9, 15, 3, "R6");
        ctl(1'b0, 1'b0, 1'b0);
        expect_rd(4'h0, ctl_exp(1'b0, 1'b0, 1'b0, img[9][13]), "R3");
        ctl(1'b1, 1'b0, 1'b1);
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b1, 1'b0, 1'b0);
        expect_rd(4'h0, ctl_exp(1'b1, 1'b0, 1'b0, img[9][13]), "R3");

        // R4: select rise without clock change clears the read
        ctl(1'b1, 1'b1, 1'b0);
        expect_rd(4'h0, ctl_exp(1'b1, 1'b1, 1'b0, 1'b1), "R4");
        send_cmd(3'b110, 6'd12, 8);
        read_bits(12, 15, 4, "R4");

        // R12: writes with unchanged clock must not shift
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        ctl(1'b0, 1'b1, 1'b1);
        ctl(1'b0, 1'b1, 1'b0);
        ctl(1'b0, 1'b1, 1'b1);
        send_cmd(3'b110, 6'd20, 8);
        read_bits(20, 15, 16, "R12");

        // R13: select and clock rise together, first bit counts
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b1, 1'b1, 1'b1);
        send_cmd(3'b110, 6'd33, 7);
        read_bits(33, 15, 16, "R13");

        // R9: word-read with start, boundary address 63
        wr(4'h4, 32'h0000_0A01);
        expect_rd(4'h4, {img[10], 16'h0A10}, "R9");
        wr(4'h4, 32'h0000_3F01);
        expect_rd(4'h4, {img[63], 16'h3F10}, "R9");
        // R10: out-of-range addresses
        wr(4'h4, 32'h0000_4001);
        expect_rd(4'h4, 32'h0000_4010, "R10");
        wr(4'h4, 32'h0000_FF01);
        expect_rd(4'h4, 32'h0000_FF10, "R10");
        // R11: start clear returns the written value
        wr(4'h4, 32'h1234_5670);
        expect_rd(4'h4, 32'h1234_5670, "R11");

        // R14: reload a word, both paths see it
        load(40, 16'hC3A5);
        wr(4'h4, 32'h0000_2801);
        expect_rd(4'h4, 32'hC3A5_2810, "R14");
        ctl(1'b0, 1'b0, 1'b0);
        ctl(1'b0, 1'b1, 1'b0);
        send_cmd(3'b110, 6'd40, 8);
        read_bits(40, 15, 16, "R14");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule